// File: doc/BRIEF.md
# Flag-Setting Compare and Condition Unit

This block keeps a four-bit status word (negative, zero, carry, overflow) and updates it from four compare-style operations. Each of them computes a value only to derive flags from it and writes no destination. The compare operations are subtract-compare and add-compare. The test operations are AND-test and XOR-test. The block also evaluates a four-bit condition code against the held flags. That gives a combinational pass signal.

Every operation is conditional. This includes the two arithmetic operations, ADD and SUB, which write a sum or difference into one register of a two-entry result bank. An operation takes effect on the clock edge after its start strobe only if the condition passes against the flags held before that edge. Otherwise it changes neither flags nor registers. The second operand is either the full operand input or an 8-bit immediate that is zero-extended. The test operations may take their carry from an external shifter.

Top module: `flag_cond_unit`

## Requirements
- R1: A synchronous active-high reset clears all four flags and both result registers to zero.
- R2: `cond_pass` is combinational from `cond` and the held flags (flags[3]=N, flags[2]=Z, flags[1]=C, flags[0]=V), as follows:
  - 0000 passes on Z=1 and 0001 on Z=0.
  - 0010 passes on C=1 and 0011 on C=0.
  - 0100 passes on N=1 and 0101 on N=0.
  - 0110 passes on V=1 and 0111 on V=0.
  - 1000 passes on C=1 and Z=0.
  - 1001 passes on C=0 or Z=1.
  - 1010 passes on N=V and 1011 on N≠V.
  - 1100 passes on Z=0 and N=V.
  - 1101 passes on Z=1 or N≠V.
- R3: Condition 1110 always passes and 1111 never passes.
- R4: Opcode 000 (subtract-compare) sets N and Z from A−B. C is set to 1 when no borrow occurs. V is set when the signed difference overflows. No register is written.
- R5: Opcode 001 (add-compare) sets N and Z from A+B. C is the carry out of bit 31. V is set when the signed sum overflows. No register is written.
- R6: Opcodes 010 (AND-test) and 011 (XOR-test) set N and Z from A&B and A^B respectively. C takes `sh_carry` only when `sh_valid` is 1 and is otherwise kept. V is always kept.
- R7: Opcodes 100 (ADD) and 101 (SUB) write A+B or A−B into `res0` when `dst_sel`=0 and into `res1` when `dst_sel`=1. The flags and the other register are left unchanged.
- R8: When `start` is high but the condition fails, flags and both registers stay unchanged.
- R9: When `imm_en`=1, the second operand is `imm8` zero-extended to 32 bits instead of `opb`.
- R10: With `start` low, or with opcode 110 or 111, nothing changes.
- R11: The effect lands on the clock edge after `start`. Back-to-back operations each see the flags left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue strobe for the presented operation |
| opcode | input | 3 | Operation select |
| cond | input | 4 | Condition code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (register form) |
| imm_en | input | 1 | Use the immediate as the second operand |
| imm8 | input | 8 | Immediate value, zero-extended |
| sh_carry | input | 1 | Shifter carry-out |
| sh_valid | input | 1 | Second operand was shifted; `sh_carry` is meaningful |
| dst_sel | input | 1 | Result register select for ADD/SUB |
| flags | output | 4 | Held N, Z, C, V (bit 3 down to bit 0) |
| cond_pass | output | 1 | Condition evaluated against held flags |
| res0 | output | 32 | Result register 0 |
| res1 | output | 32 | Result register 1 |

## Verification
The condition check and the flag update fall on the same edge. An operation issued right after a flag-setting one must be judged against the freshly written flags, and must not see the flags its own edge is about to produce. The bench provokes this by issuing operations every cycle with no gaps. It sweeps every opcode against every condition code over operand pairs that include 0x80000000/1 and 0xFFFFFFFF/1. It then runs a pseudo-random stream. A behavioural model checks `cond_pass` before each edge and checks flags and both registers after it.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

    typedef enum logic [2:0] {
        OP_CMPS = 3'd0,
        OP_CMPA = 3'd1,
        OP_TAND = 3'd2,
        OP_TXOR = 3'd3,
        OP_ADD  = 3'd4,
        OP_SUB  = 3'd5,
        OP_NOP6 = 3'd6,
        OP_NOP7 = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic logic cond_holds(cond_e cc, nzcv_t f);
        logic r;
        case (cc)
            CC_EQ:   r = f.z;
            CC_NE:   r = !f.z;
            CC_CS:   r = f.c;
            CC_CC:   r = !f.c;
            CC_MI:   r = f.n;
            CC_PL:   r = !f.n;
            CC_VS:   r = f.v;
            CC_VC:   r = !f.v;
            CC_HI:   r = f.c && !f.z;
            CC_LS:   r = !f.c || f.z;
            CC_GE:   r = (f.n == f.v);
            CC_LT:   r = (f.n != f.v);
            CC_GT:   r = !f.z && (f.n == f.v);
            CC_LE:   r = f.z || (f.n != f.v);
            CC_AL:   r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import fcu_pkg::*;
(
    input  cond_e cond,
    input  nzcv_t fl,
    output logic  pass
);

    always_comb pass = cond_holds(cond, fl);

    always_comb begin
        // R3
        if (cond == CC_AL) al_pass_chk: assert (pass);
        // R3
        if (cond == CC_NV) nv_block_chk: assert (!pass);
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import fcu_pkg::*;
#(
    parameter int DW = 32
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sh_carry,
    input  logic          sh_valid,
    input  nzcv_t         fl_in,
    output nzcv_t         fl_out,
    output logic          fl_we,
    output logic [DW-1:0] res,
    output logic          res_we
);

    localparam int MSB = DW - 1;

    logic [DW:0]   sum_x;
    logic [DW:0]   dif_x;
    logic [DW-1:0] and_v;
    logic [DW-1:0] xor_v;

    always_comb begin
        sum_x = {1'b0, a} + {1'b0, b};
        dif_x = {1'b0, a} + {1'b0, ~b} + {{DW{1'b0}}, 1'b1};
        and_v = a & b;
        xor_v = a ^ b;
    end

    always_comb begin
        fl_out = fl_in;
        fl_we  = 1'b0;
        res    = '0;
        res_we = 1'b0;
        case (op)
            OP_CMPS: begin
                fl_we    = 1'b1;
                fl_out.n = dif_x[MSB];
                fl_out.z = (dif_x[MSB:0] == '0);
                fl_out.c = dif_x[DW];
                fl_out.v = (a[MSB] != b[MSB]) && (dif_x[MSB] != a[MSB]);
            end
            OP_CMPA: begin
                fl_we    = 1'b1;
                fl_out.n = sum_x[MSB];
                fl_out.z = (sum_x[MSB:0] == '0);
                fl_out.c = sum_x[DW];
                fl_out.v = (a[MSB] == b[MSB]) && (sum_x[MSB] != a[MSB]);
            end
            OP_TAND, OP_TXOR: begin
                fl_we    = 1'b1;
                fl_out.n = (op == OP_TAND) ? and_v[MSB] : xor_v[MSB];
                fl_out.z = (op == OP_TAND) ? (and_v == '0) : (xor_v == '0);
                if (sh_valid) fl_out.c = sh_carry;
            end
            OP_ADD: begin
                res    = sum_x[MSB:0];
                res_we = 1'b1;
            end
            OP_SUB: begin
                res    = dif_x[MSB:0];
                res_we = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/result_bank.sv
module result_bank #(
    parameter int DW   = 32,
    parameter int NREG = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [SW-1:0]            sel,
    input  logic [DW-1:0]            din,
    output logic [NREG-1:0][DW-1:0]  q
);

    localparam int SW = (NREG > 1) ? $clog2(NREG) : 1;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= '0;
            else if (we && (sel == SW'(i)))
                q[i] <= din;
        end
    end

endmodule

// File: rtl/flag_cond_unit.sv
module flag_cond_unit
    import fcu_pkg::*;
#(
    parameter int DW   = 32,
    parameter int IMMW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2:0]      opcode,
    input  logic [3:0]      cond,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    input  logic            imm_en,
    input  logic [IMMW-1:0] imm8,
    input  logic            sh_carry,
    input  logic            sh_valid,
    input  logic            dst_sel,
    output logic [3:0]      flags,
    output logic            cond_pass,
    output logic [DW-1:0]   res0,
    output logic [DW-1:0]   res1
);

    localparam int NREG = 2;
    localparam int PADW = DW - IMMW;

    nzcv_t                   flag_q;
    nzcv_t                   flag_nx;
    logic                    alu_fwe;
    logic                    alu_rwe;
    logic [DW-1:0]           alu_res;
    logic [DW-1:0]           opb_eff;
    logic                    go;
    logic [NREG-1:0][DW-1:0] bank_q;

    always_comb opb_eff = imm_en ? {{PADW{1'b0}}, imm8} : opb;

    cond_eval u_cond (
        .cond (cond_e'(cond)),
        .fl   (flag_q),
        .pass (cond_pass)
    );

    flag_alu #(.DW(DW)) u_alu (
        .op       (op_e'(opcode)),
        .a        (opa),
        .b        (opb_eff),
        .sh_carry (sh_carry),
        .sh_valid (sh_valid),
        .fl_in    (flag_q),
        .fl_out   (flag_nx),
        .fl_we    (alu_fwe),
        .res      (alu_res),
        .res_we   (alu_rwe)
    );

    always_comb go = start && cond_pass;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= '0;
        else if (go && alu_fwe)
            flag_q <= flag_nx;
    end

    result_bank #(.DW(DW), .NREG(NREG)) u_bank (
        .clk (clk),
        .rst (rst),
        .we  (go && alu_rwe),
        .sel (dst_sel),
        .din (alu_res),
        .q   (bank_q)
    );

    always_comb begin
        flags = flag_q;
        res0  = bank_q[0];
        res1  = bank_q[1];
    end

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(flags) && $stable(res0) && $stable(res1)));

    // R8
    fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !cond_pass) |=> ($stable(flags) && $stable(res0) && $stable(res1)));

    // R6
    test_keeps_v_chk: assert property (@(posedge clk) disable iff (rst)
        (start && cond_pass && (opcode == 3'd2 || opcode == 3'd3)) |=> $stable(flags[0]));

    // R7
    arith_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (start && (opcode == 3'd4 || opcode == 3'd5)) |=> $stable(flags));

    // R4
    cmp_equal_chk: assert property (@(posedge clk) disable iff (rst)
        (start && cond_pass && opcode == 3'd0 && !imm_en && opa == opb)
        |=> (flags[2] && flags[1] && !flags[0]));

endmodule

// File: tb/sim_flag_cond_unit.sv
`timescale 1ns/1ps
module sim_flag_cond_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  opcode = '0;
    logic [3:0]  cond = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        imm_en = 1'b0;
    logic [7:0]  imm8 = '0;
    logic        sh_carry = 1'b0;
    logic        sh_valid = 1'b0;
    logic        dst_sel = 1'b0;
    logic [3:0]  flags;
    logic        cond_pass;
    logic [31:0] res0;
    logic [31:0] res1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    logic        mn = 0, mz = 0, mc = 0, mv = 0;
    logic [31:0] mr0 = '0, mr1 = '0;

    always #10 clk = ~clk;

    flag_cond_unit u0 (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .cond(cond),
        .opa(opa), .opb(opb), .imm_en(imm_en), .imm8(imm8),
        .sh_carry(sh_carry), .sh_valid(sh_valid), .dst_sel(dst_sel),
        .flags(flags), .cond_pass(cond_pass), .res0(res0), .res1(res1)
    );

    function automatic bit model_cond(int cc, logic n, logic z, logic c, logic v);
        if (cc == 0)  return z == 1;
        if (cc == 1)  return z == 0;
        if (cc == 2)  return c == 1;
        if (cc == 3)  return c == 0;
        if (cc == 4)  return n == 1;
        if (cc == 5)  return n == 0;
        if (cc == 6)  return v == 1;
        if (cc == 7)  return v == 0;
        if (cc == 8)  return (c == 1) && (z == 0);
        if (cc == 9)  return (c == 0) || (z == 1);
        if (cc == 10) return n == v;
        if (cc == 11) return n != v;
        if (cc == 12) return (z == 0) && (n == v);
        if (cc == 13) return (z == 1) || (n != v);
        if (cc == 14) return 1;
        return 0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    string last_tag = "R1";

    task automatic compare_state();
        check({last_tag, " flags"}, {28'd0, flags}, {28'd0, mn, mz, mc, mv});
        check({last_tag, " res0"}, res0, mr0);
        check({last_tag, " res1"}, res1, mr1);
    endtask

    // One issue slot: check previous result, drive, check pass, advance model.
    task automatic issue(bit st, int op, int cc, logic [31:0] a, logic [31:0] b,
                         bit ie, logic [7:0] im, bit sc, bit sv, bit ds);
        logic [31:0] be;
        longint sa, sb, sr;
        logic [32:0] w;
        logic [31:0] t;
        bit p;
        @(negedge clk);
        compare_state();
        start = st; opcode = op[2:0]; cond = cc[3:0]; opa = a; opb = b;
        imm_en = ie; imm8 = im; sh_carry = sc; sh_valid = sv; dst_sel = ds;
        #2;
        p = model_cond(cc, mn, mz, mc, mv);
        if (cc >= 14) check("R3 pass", {31'd0, cond_pass}, {31'd0, p});
        else          check("R2 pass", {31'd0, cond_pass}, {31'd0, p});
        be = ie ? {24'd0, im} : b;
        sa = longint'(signed'(a));
        sb = longint'(signed'(be));
        if (!st || op > 5) last_tag = "R10";
        else if (!p) last_tag = "R8";
        else begin
            last_tag = ie ? "R9" : "R11";
            case (op)
                0: begin
                    w = {1'b0, a} - {1'b0, be};
                    sr = sa - sb;
                    mn = w[31]; mz = (w[31:0] == 0); mc = !w[32];
                    mv = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
                    if (!ie) last_tag = "R4";
                end
                1: begin
                    w = {1'b0, a} + {1'b0, be};
                    sr = sa + sb;
                    mn = w[31]; mz = (w[31:0] == 0); mc = w[32];
                    mv = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
                    if (!ie) last_tag = "R5";
                end
                2, 3: begin
                    t = (op == 2) ? (a & be) : (a ^ be);
                    mn = t[31]; mz = (t == 0);
                    if (sv) mc = sc;
                    if (!ie) last_tag = "R6";
                end
                default: begin
                    t = (op == 4) ? (a + be) : (a - be);
                    if (ds) mr1 = t; else mr0 = t;
                    if (!ie) last_tag = "R7";
                end
            endcase
        end
    endtask

    logic [31:0] seed = 32'h1234_5678;
    function automatic logic [31:0] nxt(logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    logic [31:0] pa [6];
    logic [31:0] pb [6];

    initial begin
        pa[0] = 32'h8000_0000; pb[0] = 32'h0000_0001;
        pa[1] = 32'hFFFF_FFFF; pb[1] = 32'h0000_0001;
        pa[2] = 32'h0000_0000; pb[2] = 32'h0000_0000;
        pa[3] = 32'h7FFF_FFFF; pb[3] = 32'h0000_0001;
        pa[4] = 32'h0000_0005; pb[4] = 32'h0000_0007;
        pa[5] = 32'h0000_0001; pb[5] = 32'h8000_0000;

        repeat (3) @(posedge clk);
        // R1: load garbage-free state then reset check
        @(negedge clk);
        rst = 1'b0;
        last_tag = "R1";
        @(negedge clk);
        compare_state();

        // exhaustive opcode x condition sweep over the boundary pairs
        for (int op = 0; op < 8; op++)
            for (int cc = 0; cc < 16; cc++)
                for (int p = 0; p < 6; p++)
                    issue(1'b1, op, cc, pa[p], pb[p], ((cc + p) % 5) == 0,
                          pa[p][7:0] ^ 8'h81, cc[0], p[0], cc[1]);

        // pseudo-random stream with idle slots
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r1, r2, r3;
            seed = nxt(seed); r1 = seed;
            seed = nxt(seed); r2 = seed;
            seed = nxt(seed); r3 = seed;
            if (r3[9]) r2 = r1;
            issue(r3[2:0] != 3'd0, int'(r3[5:3]), int'(r3[13:10]), r1, r2,
                  r3[14] & r3[15], r3[23:16], r3[24], r3[25], r3[26]);
        end

        @(negedge clk);
        compare_state();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule